// File: doc/BRIEF.md
# Elastic-Store Transmit Jitter Attenuator

This block sits in a line transmit path and strips short-term timing jitter from a serial bit stream. Bits arrive on a jittery transmit clock, either as a positive/negative rail pair or as a single data rail, and are stored in a small bit-wide elastic store. They leave on a bit strobe made by dividing a local oscillator that runs at eight times the nominal bit rate, so the output timing follows the oscillator and not the incoming clock.

Each output bit normally lasts eight oscillator cycles. When the fill level seen in the oscillator domain approaches either end of the store, that single bit is made one oscillator cycle shorter or longer. The launch then moves by one eighth of a unit interval, and the store can neither overrun nor run dry. A signed trim code, proportional to how far the fill level sits from the midpoint, is refreshed at a fixed bit interval. External logic uses it to pull the oscillator toward the average incoming rate. The write pointer crosses into the oscillator domain as Gray code through two flip-flops. Each domain has its own reset synchronizer.

Top module: `jit_atten`

## Requirements
- R1: While reset is asserted, line_pos, line_neg, line_stb and osc_trim are all zero.
- R2: The store is preloaded half full (16 of 32 positions), so output bits 0 to 15 after reset are driven as zero. Output bit k (k >= 16) equals input bit k-16, in order, with no bit lost or repeated across period corrections.
- R3: With dual_rail low, tx_neg_in is ignored and stored as zero. Starting 22 output bits after the switch, line_neg stays zero.
- R4: When the fill level seen at a bit start lies strictly between 2 and 30, that bit lasts 8 oscillator cycles.
- R5: When the fill level seen at a bit start is 30 or more, that bit lasts 7 oscillator cycles (launched one eighth of a bit early).
- R6: When the fill level seen at a bit start is 2 or less, that bit lasts 9 oscillator cycles (launched one eighth of a bit late).
- R7: Every bit period is 7, 8 or 9 oscillator cycles, so at most one correction is applied per bit. The bit strobe line_stb is a one-cycle pulse that coincides with new data on the line outputs.
- R8: With the input clock centred on the oscillator rate, input phase wander of plus or minus 4 unit intervals causes no period correction.
- R9: osc_trim is a 4-bit two's complement value equal to (fill - 16) shifted right arithmetically by one, clamped to -8..7. It changes only on the 256th, 512th, ... bit strobe after reset.
- R10: After reset is released, the third rising tx_clk edge stores the first input bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Local oscillator, eight times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain synchronously |
| tx_clk | input | 1 | Jittery incoming bit clock; data sampled on its rising edge |
| dual_rail | input | 1 | 1: both rails stored; 0: single rail, negative rail ignored |
| tx_pos_in | input | 1 | Positive rail (or single data rail) in |
| tx_neg_in | input | 1 | Negative rail in |
| line_pos | output | 1 | Positive rail out, held for one bit period |
| line_neg | output | 1 | Negative rail out, held for one bit period |
| line_stb | output | 1 | One-cycle pulse marking the start of each output bit |
| osc_trim | output | 4 | Signed oscillator trim code |

## Verification
The bench drives four long phases without any reset between them: centred rate with square-wave phase wander, a fast input, a slow input, then a switch to single rail. Every output bit is compared against the bit written 16 positions earlier. A divider that corrected too late, or corrected in the wrong direction, would overrun or drain the store, and the comparison would then show a bit mismatch. The bench also tallies bit periods per phase. Corrections that fire during centred wander, lengthened bits under a fast input, or periods outside 7 to 9 cycles all show up there. The trim code is checked for sign and magnitude at the end of each drifting phase, and for changing only on multiples of 256 strobes. A single-rail path that still passed the negative rail would fail the settling check.

// File: rtl/ja_pkg.sv
package ja_pkg;

  // Length chosen for the next output bit period.
  typedef enum logic [1:0] {
    PER_NOM   = 2'd0,
    PER_SHORT = 2'd1,
    PER_LONG  = 2'd2
  } per_sel_e;

endpackage

// File: rtl/ja_rst_sync.sv
module ja_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];

endmodule

// File: rtl/ja_wr_side.sv
module ja_wr_side #(
  parameter int DEPTH = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         dual_in,
  input  logic                         pos_in,
  input  logic                         neg_in,
  output logic [DEPTH-1:0]             mem_p,
  output logic [DEPTH-1:0]             mem_n,
  output logic [$clog2(DEPTH):0]       wr_gray
);

  localparam int AW      = $clog2(DEPTH);
  localparam int PW      = AW + 1;
  localparam int PRELOAD = DEPTH / 2;
  localparam logic [PW-1:0] PRE_B = PW'(PRELOAD);
  localparam logic [PW-1:0] PRE_G = PW'(PRELOAD ^ (PRELOAD >> 1));

  logic [PW-1:0]    wptr_q, wptr_d, gray_d;
  logic [1:0]       mode_q;
  logic [DEPTH-1:0] mp_d, mn_d;

  // Next-state: advance pointer, place both rails at the current slot.
  always_comb begin
    wptr_d = wptr_q + PW'(1);
    gray_d = wptr_d ^ (wptr_d >> 1);
    mp_d   = mem_p;
    mn_d   = mem_n;
    mp_d[wptr_q[AW-1:0]] = pos_in;
    mn_d[wptr_q[AW-1:0]] = neg_in & mode_q[1];
  end

  // Pointer, Gray copy and mode synchronizer (reset to dual rail).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= PRE_B;
      wr_gray <= PRE_G;
      mode_q  <= 2'b11;
    end else begin
      wptr_q  <= wptr_d;
      wr_gray <= gray_d;
      mode_q  <= {mode_q[0], dual_in};
    end
  end

  // Storage carries no reset; unwritten slots are masked on the read side.
  always_ff @(posedge clk) begin
    if (rst_n) begin
      mem_p <= mp_d;
      mem_n <= mn_d;
    end
  end

  a_r3_single_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q[1] |=> !mem_n[$past(wptr_q[AW-1:0])]);

endmodule

// File: rtl/ja_bit_div.sv
module ja_bit_div
  import ja_pkg::*;
#(
  parameter int DIV = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  per_sel_e sel,
  output logic     strobe
);

  localparam int CW = $clog2(DIV + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    strobe = (cnt_q == '0);
    cnt_d  = cnt_q - CW'(1);
    if (strobe) begin
      unique case (sel)
        PER_SHORT: cnt_d = CW'(DIV - 2);
        PER_LONG:  cnt_d = CW'(DIV);
        default:   cnt_d = CW'(DIV - 1);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  a_r7_gap: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);

  a_r7_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DIV));

endmodule

// File: rtl/ja_trim_ctl.sv
module ja_trim_ctl #(
  parameter int DEPTH = 32,
  parameter int TW    = 4,
  parameter int UPD   = 256
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   strobe,
  input  logic [$clog2(DEPTH):0] occ,
  output logic [TW-1:0]          trim
);

  localparam int PW  = $clog2(DEPTH) + 1;
  localparam int UCW = $clog2(UPD);
  localparam logic signed [PW:0] MID_S  = (PW+1)'(DEPTH / 2);
  localparam logic signed [PW:0] TMAX_S = (PW+1)'(2 ** (TW - 1) - 1);
  localparam logic signed [PW:0] TMIN_S = (PW+1)'(-(2 ** (TW - 1)));

  logic [UCW-1:0]    ucnt_q, ucnt_d;
  logic [TW-1:0]     trim_d;
  logic              upd;
  logic signed [PW:0] diff, half;

  always_comb begin
    upd    = strobe && (ucnt_q == UCW'(UPD - 1));
    diff   = $signed({1'b0, occ}) - MID_S;
    half   = diff >>> 1;
    ucnt_d = ucnt_q;
    trim_d = trim;
    if (strobe) ucnt_d = upd ? '0 : ucnt_q + UCW'(1);
    if (upd) begin
      if (half > TMAX_S)      trim_d = TW'(TMAX_S);
      else if (half < TMIN_S) trim_d = TW'(TMIN_S);
      else                    trim_d = TW'(half);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ucnt_q <= '0;
      trim   <= '0;
    end else begin
      ucnt_q <= ucnt_d;
      trim   <= trim_d;
    end
  end

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(trim));

endmodule

// File: rtl/jit_atten.sv
module jit_atten
  import ja_pkg::*;
#(
  parameter int DEPTH     = 32,
  parameter int DIV       = 8,
  parameter int TRIM_W    = 4,
  parameter int TRIM_BITS = 256
) (
  input  logic              osc_clk,
  input  logic              rst_n,
  input  logic              tx_clk,
  input  logic              dual_rail,
  input  logic              tx_pos_in,
  input  logic              tx_neg_in,
  output logic              line_pos,
  output logic              line_neg,
  output logic              line_stb,
  output logic [TRIM_W-1:0] osc_trim
);

  localparam int AW      = $clog2(DEPTH);
  localparam int PW      = AW + 1;
  localparam int PRELOAD = DEPTH / 2;
  localparam int HI_MARK = DEPTH - 2;
  localparam int LO_MARK = 2;
  localparam logic [PW-1:0] PRE_G = PW'(PRELOAD ^ (PRELOAD >> 1));

  logic osc_rst_n, tx_rst_n;

  ja_rst_sync u_rs_osc (.clk(osc_clk), .arst_n(rst_n), .srst_n(osc_rst_n));
  ja_rst_sync u_rs_tx  (.clk(tx_clk),  .arst_n(rst_n), .srst_n(tx_rst_n));

  logic [DEPTH-1:0] mem_p, mem_n;
  logic [PW-1:0]    wr_gray;

  ja_wr_side #(.DEPTH(DEPTH)) u_wr (
    .clk     (tx_clk),
    .rst_n   (tx_rst_n),
    .dual_in (dual_rail),
    .pos_in  (tx_pos_in),
    .neg_in  (tx_neg_in),
    .mem_p   (mem_p),
    .mem_n   (mem_n),
    .wr_gray (wr_gray)
  );

  // Two-stage Gray synchronizer into the oscillator domain.
  logic [PW-1:0] g_s1, g_s2, wbin;

  always_ff @(posedge osc_clk or negedge osc_rst_n) begin
    if (!osc_rst_n) begin
      g_s1 <= PRE_G;
      g_s2 <= PRE_G;
    end else begin
      g_s1 <= wr_gray;
      g_s2 <= g_s1;
    end
  end

  always_comb begin
    for (int i = 0; i < PW; i++) wbin[i] = ^(g_s2 >> i);
  end

  // Read side: fill level, period choice, output launch.
  logic [PW-1:0] rd_q, rd_d, occ;
  logic          primed_q, primed_d, pos_d, neg_d, strobe;
  per_sel_e      sel;

  always_comb begin
    occ = wbin - rd_q;
    if (occ >= PW'(HI_MARK))      sel = PER_SHORT;
    else if (occ <= PW'(LO_MARK)) sel = PER_LONG;
    else                          sel = PER_NOM;
    rd_d     = rd_q;
    primed_d = primed_q;
    pos_d    = line_pos;
    neg_d    = line_neg;
    if (strobe) begin
      rd_d     = rd_q + PW'(1);
      primed_d = primed_q | (rd_q[AW-1:0] == AW'(PRELOAD));
      pos_d    = primed_d & mem_p[rd_q[AW-1:0]];
      neg_d    = primed_d & mem_n[rd_q[AW-1:0]];
    end
  end

  always_ff @(posedge osc_clk or negedge osc_rst_n) begin
    if (!osc_rst_n) begin
      rd_q     <= '0;
      primed_q <= 1'b0;
      line_pos <= 1'b0;
      line_neg <= 1'b0;
      line_stb <= 1'b0;
    end else begin
      rd_q     <= rd_d;
      primed_q <= primed_d;
      line_pos <= pos_d;
      line_neg <= neg_d;
      line_stb <= strobe;
    end
  end

  ja_bit_div #(.DIV(DIV)) u_div (
    .clk    (osc_clk),
    .rst_n  (osc_rst_n),
    .sel    (sel),
    .strobe (strobe)
  );

  ja_trim_ctl #(.DEPTH(DEPTH), .TW(TRIM_W), .UPD(TRIM_BITS)) u_trim (
    .clk    (osc_clk),
    .rst_n  (osc_rst_n),
    .strobe (strobe),
    .occ    (occ),
    .trim   (osc_trim)
  );

  a_r2_no_overflow: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
    occ <= PW'(DEPTH));

  a_r2_quiet_start: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
    !primed_q |-> (!line_pos && !line_neg));

endmodule

// File: tb/jit_atten_tb.sv
`timescale 1ns/1ps
module jit_atten_tb;

  logic       osc_clk = 1'b0;
  logic       rst_n, tx_clk, dual_rail, tx_pos_in, tx_neg_in;
  logic       line_pos, line_neg, line_stb;
  logic [3:0] osc_trim;

  jit_atten u_dut (
    .osc_clk   (osc_clk),
    .rst_n     (rst_n),
    .tx_clk    (tx_clk),
    .dual_rail (dual_rail),
    .tx_pos_in (tx_pos_in),
    .tx_neg_in (tx_neg_in),
    .line_pos  (line_pos),
    .line_neg  (line_neg),
    .line_stb  (line_stb),
    .osc_trim  (osc_trim)
  );

  always #4 osc_clk = ~osc_clk;  // 125 MHz oscillator

  int   tests = 0, fails = 0;
  logic sent_p [0:4095];
  logic sent_n [0:4095];
  int   nsent = 0, nstb = 0, cyc = 0, last_cyc = -1, ph = 0, sw_k = -1, k, per;
  int   cnt7 [0:3], cnt8 [0:3], cnt9 [0:3];
  logic [3:0]  prev_trim = 4'd0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic p, input logic n, input int prd);
    tx_pos_in = p;
    tx_neg_in = n;
    #(prd / 2);
    sent_p[nsent] = p;
    sent_n[nsent] = dual_rail ? n : 1'b0;
    nsent++;
    tx_clk = 1'b1;
    #(prd - prd / 2);
    tx_clk = 1'b0;
  endtask

  task automatic send_rand(input int prd, input bit force_neg0);
    logic p, n;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    p = lfsr[0];
    n = lfsr[1] & ~lfsr[0] & ~force_neg0;
    send(p, n, prd);
  endtask

  // Output monitor, sampled on the falling oscillator edge.
  always @(negedge osc_clk) begin
    if (rst_n === 1'b1) begin
      cyc++;
      if (line_stb) begin
        k = nstb;
        nstb++;
        if (last_cyc >= 0) begin
          per = cyc - last_cyc;
          chk(per >= 7 && per <= 9, "R7 period range", per, 8);
          if (per == 7) cnt7[ph]++;
          if (per == 8) cnt8[ph]++;
          if (per == 9) cnt9[ph]++;
        end
        last_cyc = cyc;
        if (k < 16) begin
          chk(!line_pos && !line_neg, "R2 preload bits zero", {line_pos, line_neg}, 0);
        end else if (k - 16 < nsent) begin
          chk(line_pos == sent_p[k-16], "R2 R10 pos order", line_pos, sent_p[k-16]);
          chk(line_neg == sent_n[k-16], "R2 R3 neg order", line_neg, sent_n[k-16]);
        end
        if (sw_k >= 0 && k >= sw_k + 22)
          chk(!line_neg, "R3 single-rail settle", line_neg, 0);
      end
      if (osc_trim != prev_trim) begin
        chk(nstb % 256 == 0, "R9 trim update spacing", nstb, 256);
        prev_trim = osc_trim;
      end
    end
  end

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", nstb, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin cnt7[i] = 0; cnt8[i] = 0; cnt9[i] = 0; end
    rst_n = 1'b0; tx_clk = 1'b0; dual_rail = 1'b1; tx_pos_in = 1'b0; tx_neg_in = 1'b0;
    repeat (5) @(negedge osc_clk);
    // R1: reset state
    chk(!line_pos && !line_neg && !line_stb, "R1 reset outputs", {line_pos, line_neg, line_stb}, 0);
    chk(osc_trim == 4'd0, "R1 reset trim", osc_trim, 0);
    #2 rst_n = 1'b1;
    // R10: two edges release the write-side reset; data begins on the third.
    repeat (2) begin #8 tx_clk = 1'b1; #8 tx_clk = 1'b0; end

    // Phase 0: centred rate, +/-4 UI square-wave wander (R4, R8)
    ph = 0;
    for (int i = 0; i < 512; i++) send_rand((((i + 8) / 16) % 2 == 0) ? 32 : 96, 1'b0);
    chk(cnt7[0] == 0 && cnt9[0] == 0, "R8 R4 no correction", cnt7[0] + cnt9[0], 0);
    chk(cnt8[0] > 400, "R4 nominal periods", cnt8[0], 400);
    chk($signed(osc_trim) >= -3 && $signed(osc_trim) <= 3, "R9 centred trim", $signed(osc_trim), 0);

    // Phase 1: fast input, store fills, shortened bits (R5)
    ph = 1;
    for (int i = 0; i < 700; i++) send_rand(60, 1'b0);
    chk(cnt7[1] > 0, "R5 shortened bits", cnt7[1], 1);
    chk(cnt9[1] == 0, "R6 R5 no lengthened bit when fast", cnt9[1], 0);
    chk($signed(osc_trim) >= 5, "R9 fast trim positive", $signed(osc_trim), 7);

    // Phase 2: slow input, store drains, lengthened bits (R6)
    ph = 2;
    for (int i = 0; i < 800; i++) send_rand(68, 1'b0);
    chk(cnt9[2] > 0, "R6 lengthened bits", cnt9[2], 1);
    chk($signed(osc_trim) <= -5, "R9 slow trim negative", $signed(osc_trim), -7);

    // Phase 3: single rail, negative rail toggling but ignored (R3)
    ph = 3;
    for (int i = 0; i < 4; i++) send_rand(64, 1'b1);
    dual_rail = 1'b0;
    sw_k = nstb;
    for (int i = 0; i < 4; i++) send_rand(64, 1'b1);
    for (int i = 0; i < 240; i++) send_rand(64, 1'b0);
    chk(nstb > sw_k + 22, "R3 settle window reached", nstb, sw_k + 22);

    #40;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule